// File: doc/BRIEF.md
# Triangle Wave Sequencer with Position Load

This block produces the amplitude of a triangle-wave tone channel. A down-counting period divider sets the pitch. Each time the divider expires, a 5-bit step counter advances by one, wrapping from 31 back to 0. The step value is folded into a 4-bit amplitude that climbs 0..15 and then falls 15..0. One full waveform therefore spans 32 steps.

A load strobe with a 5-bit position lets external logic overwrite the step counter in any cycle. The waveform jumps to that point at once. The divider is not touched, so the pitch and the timing of the next advance stay as they were.

Surrounding logic drives the period and the enable. The amplitude output goes to a mixer outside this block.

Top module: `tri_seq_gen`

## Requirements
- R1: While reset is asserted and directly after its release, `amp_o` is 0. Reset clears both the step counter and the divider to 0.
- R2: When the step counter holds a value from 0 to 15, `amp_o` equals that value.
- R3: When the step counter holds a value from 16 to 31 (step bit 4 set, falling half), `amp_o` equals 31 minus the step.
- R4: With `en_i` high, the divider counts down by one each cycle. In the cycle it is at 0, it reloads `period_i` and advances the step counter by one, modulo 32. The step therefore advances once every `period_i`+1 enabled cycles.
- R5: A cycle with `load_i` high sets the step counter to `load_pos_i`. From the next clock edge, `amp_o` shows the folded value of that position.
- R6: A load leaves the divider's count unchanged. The next advance after a load occurs in the same cycle it would have occurred without the load.
- R7: If a load and a step advance fall in the same cycle, the step counter takes `load_pos_i` and not the incremented value.
- R8: While `en_i` is low, the divider and the step counter hold their values and `amp_o` holds. Counting resumes from the held divider value when `en_i` returns high.
- R9: A load with `en_i` low still sets the step counter, while the divider stays frozen.
- R10: With `period_i` = 0, the step advances on every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | 11 | Divider reload value; the step advances every period_i+1 enabled cycles |
| en_i | input | 1 | Enables the divider and step advance |
| load_i | input | 1 | Loads the step counter from load_pos_i |
| load_pos_i | input | 5 | Step position to load |
| amp_o | output | 4 | Folded triangle amplitude |

## Verification
Every state change is captured by the clock edge that sees its cause, and `amp_o` is a pure fold of the step register. A load, an advance or a hold is therefore visible on `amp_o` one edge after the cycle that presents it, with no further pipeline delay.

The bench drives inputs shortly after a rising edge and keeps them stable through the next one. Its behavioural model updates on that same edge, and `amp_o` is compared one time unit after every edge. Load-against-advance collisions are placed by timing the strobe from the model's own divider count.

// File: rtl/tri_seq_pkg.sv
`timescale 1ns/1ps
package tri_seq_pkg;
  localparam int unsigned PERIOD_W = 11;
  localparam int unsigned STEP_W   = 5;
  localparam int unsigned AMP_W    = STEP_W - 1;

  typedef logic [PERIOD_W-1:0] period_t;
  typedef logic [STEP_W-1:0]   step_t;
  typedef logic [AMP_W-1:0]    amp_t;

  // rising half is identity, falling half mirrors via inversion of low bits
  function automatic amp_t fold_step(step_t s);
    return s[STEP_W-1] ? ~s[AMP_W-1:0] : s[AMP_W-1:0];
  endfunction
endpackage

// File: rtl/tri_divider.sv
`timescale 1ns/1ps
module tri_divider #(
  parameter int unsigned WIDTH = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] period_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             adv_o
);
  logic [WIDTH-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign adv_o   = en_i & at_zero;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (at_zero) cnt_q <= period_i;
      else         cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tri_step_ctr.sv
`timescale 1ns/1ps
module tri_step_ctr #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_pos_i,
  output logic [WIDTH-1:0] step_o
);
  logic [WIDTH-1:0] step_q;

  assign step_o = step_q;

  // load has priority over advance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     step_q <= '0;
    else if (load_i) step_q <= load_pos_i;
    else if (adv_i)  step_q <= step_q + 1'b1;
  end
endmodule

// File: rtl/tri_fold.sv
`timescale 1ns/1ps
module tri_fold
  import tri_seq_pkg::*;
(
  input  step_t step_i,
  output amp_t  amp_o
);
  assign amp_o = fold_step(step_i);
endmodule

// File: rtl/tri_seq_gen.sv
`timescale 1ns/1ps
module tri_seq_gen
  import tri_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                en_i,
  input  logic                load_i,
  input  logic [STEP_W-1:0]   load_pos_i,
  output logic [AMP_W-1:0]    amp_o
);
  period_t div_q;
  step_t   step_q;
  logic    adv;

  tri_divider #(.WIDTH(PERIOD_W)) i_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .period_i (period_i),
    .cnt_o    (div_q),
    .adv_o    (adv)
  );

  tri_step_ctr #(.WIDTH(STEP_W)) i_step (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .load_i     (load_i),
    .load_pos_i (load_pos_i),
    .step_o     (step_q)
  );

  tri_fold i_fold (
    .step_i (step_q),
    .amp_o  (amp_o)
  );
endmodule

// File: rtl/tri_seq_chk.sv
`timescale 1ns/1ps
module tri_seq_chk
  import tri_seq_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    en_i,
  input logic    load_i,
  input step_t   load_pos_i,
  input period_t period_i,
  input period_t div_q,
  input step_t   step_q,
  input amp_t    amp_o
);
  p_reset_amp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> amp_o == '0);

  p_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i && div_q == '0 |=> step_q == step_t'($past(step_q) + 1'b1));

  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && div_q == '0 |=> div_q == $past(period_i));

  p_load_pos_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> step_q == $past(load_pos_i));

  p_load_keeps_div_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && en_i && div_q != '0 |=> div_q == period_t'($past(div_q) - 1'b1));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !load_i |=> $stable(step_q) && $stable(div_q) && $stable(amp_o));

  p_frozen_div_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && load_i |=> $stable(div_q));

  // without loads the amplitude moves by at most one level per cycle (R2, R3)
  p_amp_smooth_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> amp_o == $past(amp_o) || amp_o == amp_t'($past(amp_o) + 1'b1)
                || amp_o == amp_t'($past(amp_o) - 1'b1));
endmodule

bind tri_seq_gen tri_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .load_i     (load_i),
  .load_pos_i (load_pos_i),
  .period_i   (period_i),
  .div_q      (div_q),
  .step_q     (step_q),
  .amp_o      (amp_o)
);

// File: tb/test_tri_seq_gen.sv
`timescale 1ns/1ps
module test_tri_seq_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] period = '0;
  logic        en = 1'b0;
  logic        load = 1'b0;
  logic [4:0]  pos = '0;
  logic [3:0]  amp;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string tag = "R1";

  int m_div = 0;
  int m_step = 0;

  always #2 clk = ~clk;

  tri_seq_gen i_tri_seq_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .period_i   (period),
    .en_i       (en),
    .load_i     (load),
    .load_pos_i (pos),
    .amp_o      (amp)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0;
      m_step = 0;
    end else begin
      bit tick;
      tick = en && (m_div == 0);
      if (en) m_div = (m_div == 0) ? int'(period) : m_div - 1;
      if (load)      m_step = int'(pos);
      else if (tick) m_step = (m_step + 1) % 32;
    end
  end

  function automatic int exp_amp(int s);
    return (s < 16) ? s : 31 - s;
  endfunction

  task automatic check(string t);
    string use_t;
    use_t = t;
    if (t == "") use_t = (m_step < 16) ? "R2" : "R3";
    checks++;
    if (int'(amp) != exp_amp(m_step)) begin
      errors++;
      $display("FAIL %s: amp_o=%0d expected %0d (step %0d)", use_t, amp, exp_amp(m_step), m_step);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      check(tag);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R1: held in reset, then released
    tag = "R1";
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R2 / R3 / R4: free run over more than one full waveform
    tag = "";
    period = 11'd3; en = 1'b1;
    cyc(140);

    // R10: period zero advances every cycle
    tag = "R10";
    period = 11'd0;
    cyc(40);

    // R5 / R6: load mid-count, divider keeps its phase
    tag = "R5";
    period = 11'd5;
    cyc(3);
    pos = 5'd9; load = 1'b1;
    cyc(1);
    load = 1'b0;
    tag = "R6";
    cyc(20);

    // R3: loads into the falling half
    tag = "R3";
    for (int p = 16; p < 32; p += 5) begin
      pos = 5'(p); load = 1'b1;
      cyc(1);
      load = 1'b0;
      cyc(4);
    end

    // R7: load lands on the cycle the divider expires
    tag = "R7";
    period = 11'd2;
    for (int k = 0; k < 3; k++) begin
      while (m_div != 0) cyc(1);
      pos = 5'(20 + k); load = 1'b1;
      cyc(1);
      load = 1'b0;
      cyc(2);
    end

    // R8: disabled, everything holds, then resumes
    tag = "R8";
    period = 11'd4;
    cyc(2);
    en = 1'b0;
    cyc(12);
    en = 1'b1;
    cyc(15);

    // R9: load while disabled
    tag = "R9";
    en = 1'b0;
    pos = 5'd30; load = 1'b1;
    cyc(1);
    load = 1'b0;
    cyc(5);
    en = 1'b1;
    cyc(20);

    // R1: asynchronous reset mid-waveform
    tag = "R1";
    #1 rst_n = 1'b0;
    #1;
    checks++;
    if (amp != 4'd0) begin
      errors++;
      $display("FAIL R1: amp_o=%0d expected 0 during reset", amp);
    end
    cyc(2);
    rst_n = 1'b1;
    en = 1'b0;
    cyc(2);

    finish_run();
  end
endmodule